// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address sequence of one SDRAM access burst. It is meant to sit inside a memory device model or a controller-side checker. When a read or write strobe is taken, the block captures the start column and the burst mode. It then presents one column address per clock until the burst completes, is cut short, or is replaced.

Four burst lengths are supported (1, 2, 4 and 8), plus a full-page length. Fixed-length bursts wrap inside the aligned block that holds the start column, in either sequential or interleaved order. A full-page burst walks the whole row, wraps from the top column to column 0, and runs until a burst stop, a precharge or a new access ends it. A single-write mode limits every write to one location, while reads keep the programmed length. Data storage and read latency are handled elsewhere.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held, and after it is released with no command, `col_valid` and `burst_done` are 0.
- R2: A read or write strobe taken at a clock edge makes `col_valid` 1 and `col_out` equal to the captured start column after that edge. Each following edge advances the burst by one address.
- R3: Length codes on `bl_code` are decoded as 0 = 1, 1 = 2, 2 = 4, 3 = 8 and 7 = full page. The codes 4, 5 and 6 behave as length 1.
- R4: With `interleave` = 0 and a fixed length L, the low log2(L) bits of the n-th address are (start low bits + n) mod L. The upper bits stay equal to those of the start column.
- R5: With `interleave` = 1 and a fixed length L, the low log2(L) bits of the n-th address equal the start low bits XOR n. The upper bits stay fixed.
- R6: In full-page mode the column rises by one per cycle and wraps from 2^COL_W-1 to 0. `interleave` has no effect in this mode. `burst_done` stays 0, and the burst continues until it is stopped.
- R7: `burst_done` is 1 in the same cycle as the last address of a fixed-length burst. `col_valid` is 0 in the next cycle unless a new access was taken.
- R8: A burst stop (`stop_cmd`) or a precharge (`pre_cmd`) taken without a new access makes `col_valid` and `burst_done` 0 after that edge.
- R9: A read or write taken during a burst restarts at the new start column with the new mode. A new access takes precedence over a burst stop or precharge taken in the same cycle.
- R10: When `single_write` is 1, a write strobe gives a one-address burst with `burst_done` set. A read still uses the programmed length.
- R11: `bl_code`, `interleave` and `single_write` are captured only when an access is taken. Changing them during a burst leaves that burst's addresses and length unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_cmd | input | 1 | Read access strobe |
| wr_cmd | input | 1 | Write access strobe |
| stop_cmd | input | 1 | Burst stop strobe |
| pre_cmd | input | 1 | Precharge strobe for the bank |
| start_col | input | COL_W | Start column of a new access |
| bl_code | input | 3 | Burst length code |
| interleave | input | 1 | 1 = interleaved wrap order, 0 = sequential |
| single_write | input | 1 | 1 = writes touch one location only |
| col_out | output | COL_W | Current column address |
| col_valid | output | 1 | `col_out` holds a burst address |
| burst_done | output | 1 | Last address of a fixed-length burst |

## Verification
Every output of this block is due one clock edge after the strobe that causes it. The first address and the valid flag appear after the edge that takes the access. Each later address follows one edge after the previous one. The end of a burst after a stop, a precharge or a done cycle is seen one edge later. The bench changes inputs only on the falling edge and reads the outputs on the next falling edge, so each check lands exactly one register stage after its stimulus. Mode inputs changed during a burst are read back through `col_out` and `burst_done` over the remaining beats.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

    // burst length codes as applied on bl_code
    typedef enum logic [2:0] {
        BLC_ONE   = 3'd0,
        BLC_TWO   = 3'd1,
        BLC_FOUR  = 3'd2,
        BLC_EIGHT = 3'd3,
        BLC_PAGE  = 3'd7
    } blen_code_e;

    // mode captured at the start of a burst
    typedef struct packed {
        logic [1:0] len_log2;   // fixed length = 2**len_log2
        logic       full_page;  // run until stopped, sequential order
        logic       ilv;        // interleaved wrap order
    } burst_mode_t;

    localparam int LEN_CODE_W = 3;

    function automatic burst_mode_t decode_mode(
        input logic [LEN_CODE_W-1:0] code,
        input logic                  ilv_req,
        input logic                  force_single
    );
        burst_mode_t m;
        m.full_page = 1'b0;
        m.ilv       = ilv_req;
        case (code)
            BLC_TWO:   m.len_log2 = 2'd1;
            BLC_FOUR:  m.len_log2 = 2'd2;
            BLC_EIGHT: m.len_log2 = 2'd3;
            BLC_PAGE: begin
                m.len_log2  = 2'd0;
                m.full_page = 1'b1;
                m.ilv       = 1'b0;
            end
            default:   m.len_log2 = 2'd0;
        endcase
        if (force_single) begin
            m.len_log2  = 2'd0;
            m.full_page = 1'b0;
        end
        return m;
    endfunction

endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec
    import sdram_colgen_pkg::*;
(
    input  logic                  rd_cmd,
    input  logic                  wr_cmd,
    input  logic [LEN_CODE_W-1:0] bl_code,
    input  logic                  interleave,
    input  logic                  single_write,
    output logic                  new_access,
    output burst_mode_t           mode
);
    logic cut_to_one;

    always_comb begin
        new_access = rd_cmd | wr_cmd;
        cut_to_one = wr_cmd & single_write;
        mode       = decode_mode(bl_code, interleave, cut_to_one);
    end
endmodule

// File: rtl/colgen_seq.sv
module colgen_seq
    import sdram_colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             new_access,
    input  logic             end_req,
    input  burst_mode_t      mode_in,
    input  logic [COL_W-1:0] col_in,
    output logic             active,
    output logic             last_beat,
    output logic [COL_W-1:0] beat,
    output logic [COL_W-1:0] start_q,
    output burst_mode_t      mode_q
);
    logic [COL_W-1:0] final_beat;

    always_comb begin
        final_beat = (COL_W'(1) << mode_q.len_log2) - COL_W'(1);
        last_beat  = active && !mode_q.full_page && (beat == final_beat);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            beat    <= '0;
            start_q <= '0;
            mode_q  <= '0;
        end else if (new_access) begin
            active  <= 1'b1;
            beat    <= '0;
            start_q <= col_in;
            mode_q  <= mode_in;
        end else if (end_req || last_beat) begin
            active  <= 1'b0;
            beat    <= '0;
        end else if (active) begin
            beat    <= beat + COL_W'(1);
        end
    end
endmodule

// File: rtl/colgen_addr.sv
module colgen_addr
    import sdram_colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] start_col,
    input  logic [COL_W-1:0] beat,
    input  burst_mode_t      mode,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] low_mask;
    logic [COL_W-1:0] seq_low;
    logic [COL_W-1:0] ilv_low;

    always_comb begin
        low_mask = (COL_W'(1) << mode.len_log2) - COL_W'(1);
        seq_low  = (start_col + beat) & low_mask;
        ilv_low  = (start_col ^ beat) & low_mask;
        if (mode.full_page)
            col = start_col + beat;
        else if (mode.ilv)
            col = (start_col & ~low_mask) | ilv_low;
        else
            col = (start_col & ~low_mask) | seq_low;
    end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import sdram_colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_cmd,
    input  logic                  wr_cmd,
    input  logic                  stop_cmd,
    input  logic                  pre_cmd,
    input  logic [COL_W-1:0]      start_col,
    input  logic [LEN_CODE_W-1:0] bl_code,
    input  logic                  interleave,
    input  logic                  single_write,
    output logic [COL_W-1:0]      col_out,
    output logic                  col_valid,
    output logic                  burst_done
);
    logic             new_access;
    burst_mode_t      mode_now;
    burst_mode_t      mode_q;
    logic             active;
    logic             last_beat;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] start_q;
    logic [COL_W-1:0] col_calc;

    colgen_mode_dec u_dec (
        .rd_cmd       (rd_cmd),
        .wr_cmd       (wr_cmd),
        .bl_code      (bl_code),
        .interleave   (interleave),
        .single_write (single_write),
        .new_access   (new_access),
        .mode         (mode_now)
    );

    colgen_seq #(.COL_W(COL_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .new_access (new_access),
        .end_req    (stop_cmd | pre_cmd),
        .mode_in    (mode_now),
        .col_in     (start_col),
        .active     (active),
        .last_beat  (last_beat),
        .beat       (beat),
        .start_q    (start_q),
        .mode_q     (mode_q)
    );

    colgen_addr #(.COL_W(COL_W)) u_addr (
        .start_col (start_q),
        .beat      (beat),
        .mode      (mode_q),
        .col       (col_calc)
    );

    assign col_out    = col_calc;
    assign col_valid  = active;
    assign burst_done = last_beat;
endmodule

// File: rtl/colgen_checker.sv
module colgen_checker #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_cmd,
    input logic             wr_cmd,
    input logic             stop_cmd,
    input logic             pre_cmd,
    input logic             single_write,
    input logic [COL_W-1:0] start_col,
    input logic [COL_W-1:0] col_out,
    input logic             col_valid,
    input logic             burst_done
);
    assert_first_col_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_cmd || wr_cmd) |=> (col_valid && col_out == $past(start_col)));

    assert_stop_ends_R8: assert property (@(posedge clk) disable iff (rst)
        (!rd_cmd && !wr_cmd && (stop_cmd || pre_cmd)) |=> (!col_valid && !burst_done));

    assert_done_has_valid_R7: assert property (@(posedge clk) disable iff (rst)
        burst_done |-> col_valid);

    assert_done_then_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (burst_done && !rd_cmd && !wr_cmd) |=> !col_valid);

    assert_single_write_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && single_write) |=> burst_done);
endmodule

bind sdram_burst_colgen colgen_checker #(.COL_W(COL_W)) u_colgen_checker (
    .clk          (clk),
    .rst          (rst),
    .rd_cmd       (rd_cmd),
    .wr_cmd       (wr_cmd),
    .stop_cmd     (stop_cmd),
    .pre_cmd      (pre_cmd),
    .single_write (single_write),
    .start_col    (start_col),
    .col_out      (col_out),
    .col_valid    (col_valid),
    .burst_done   (burst_done)
);

// File: tb/test_sdram_burst_colgen.sv
module test_sdram_burst_colgen;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 9;
    localparam int WATCHDOG   = 5000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rd_cmd = 1'b0, wr_cmd = 1'b0, stop_cmd = 1'b0, pre_cmd = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [2:0]       bl_code = 3'd0;
    logic             interleave = 1'b0, single_write = 1'b0;
    logic [COL_W-1:0] col_out;
    logic             col_valid, burst_done;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_burst_colgen #(.COL_W(COL_W)) i_sdram_burst_colgen (
        .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
        .stop_cmd(stop_cmd), .pre_cmd(pre_cmd), .start_col(start_col),
        .bl_code(bl_code), .interleave(interleave), .single_write(single_write),
        .col_out(col_out), .col_valid(col_valid), .burst_done(burst_done)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // expected column of beat n; len 0 means full page
    function automatic int exp_col(input int s, input int n, input int len, input bit ilv);
        int base, off;
        if (len == 0) return (s + n) % (1 << COL_W);
        base = s - (s % len);
        off  = ilv ? ((s % len) ^ n) : (((s % len) + n) % len);
        return base + off;
    endfunction

    // called at a falling edge; strobes are taken at the next rising edge
    task automatic kick(input bit rd, input bit wr, input int col, input int code,
                        input bit ilv, input bit sw, input bit stp, input bit pre);
        rd_cmd = rd; wr_cmd = wr; stop_cmd = stp; pre_cmd = pre;
        start_col = COL_W'(col); bl_code = 3'(code);
        interleave = ilv; single_write = sw;
        @(negedge clk);
        rd_cmd = 0; wr_cmd = 0; stop_cmd = 0; pre_cmd = 0;
    endtask

    // checks beats first..first+count-1, one per falling edge
    task automatic check_beats(input string req, input int s, input int len, input bit ilv,
                               input int first, input int count, input bit done_at_end);
        for (int i = first; i < first + count; i++) begin
            check(req, "valid", int'(col_valid), 1);
            check(req, "col", int'(col_out), exp_col(s, i, len, ilv));
            check(req, "done", int'(burst_done),
                  (done_at_end && i == first + count - 1) ? 1 : 0);
            @(negedge clk);
        end
    endtask

    task automatic check_idle(input string req);
        check(req, "valid idle", int'(col_valid), 0);
        check(req, "done idle", int'(burst_done), 0);
    endtask

    task automatic t_reset;
        check_idle("R1");
        rst = 0;
        @(negedge clk);
        check_idle("R1");
    endtask

    task automatic t_sequential;
        kick(1, 0, 13, 2, 0, 0, 0, 0);           // R4 R2: 13,14,15,12
        check_beats("R4", 13, 4, 0, 0, 4, 1);
        check_idle("R7");
        kick(0, 1, 7, 1, 0, 0, 0, 0);            // R3: length 2 -> 7,6
        check_beats("R3", 7, 2, 0, 0, 2, 1);
        check_idle("R7");
    endtask

    task automatic t_interleaved;
        kick(1, 0, 13, 3, 1, 0, 0, 0);           // R5: 13^n within 8..15
        check_beats("R5", 13, 8, 1, 0, 8, 1);
        check_idle("R7");
    endtask

    task automatic t_short_codes;
        kick(1, 0, 5, 0, 0, 0, 0, 0);            // R3 length 1
        check_beats("R3", 5, 1, 0, 0, 1, 1);
        check_idle("R3");
        kick(1, 0, 9, 5, 1, 0, 0, 0);            // R3 reserved code as length 1
        check_beats("R3", 9, 1, 0, 0, 1, 1);
        check_idle("R3");
    endtask

    task automatic t_full_page;
        kick(1, 0, 510, 7, 1, 0, 0, 0);          // R6: interleave ignored, wraps
        check_beats("R6", 510, 0, 0, 0, 6, 0);
        kick(0, 0, 0, 7, 0, 0, 1, 0);            // R8: burst stop
        check_idle("R8");
    endtask

    task automatic t_precharge;
        kick(0, 1, 16, 3, 0, 0, 0, 0);
        check_beats("R8", 16, 8, 0, 0, 2, 0);
        kick(0, 0, 0, 3, 0, 0, 0, 1);            // R8: precharge
        check_idle("R8");
    endtask

    task automatic t_restart;
        kick(1, 0, 32, 3, 0, 0, 0, 0);
        check_beats("R9", 32, 8, 0, 0, 3, 0);
        kick(1, 0, 68, 2, 0, 0, 1, 1);           // R9: new access beats stop
        check_beats("R9", 68, 4, 0, 0, 4, 1);
        check_idle("R9");
    endtask

    task automatic t_single_write;
        kick(0, 1, 40, 3, 0, 1, 0, 0);           // R10: write cut to one
        check_beats("R10", 40, 1, 0, 0, 1, 1);
        check_idle("R10");
        kick(1, 0, 41, 2, 0, 1, 0, 0);           // R10: read keeps length 4
        check_beats("R10", 41, 4, 0, 0, 4, 1);
        check_idle("R10");
    endtask

    task automatic t_mode_latch;
        kick(1, 0, 49, 2, 0, 0, 0, 0);
        check_beats("R11", 49, 4, 0, 0, 1, 0);
        bl_code = 3'd0; interleave = 1'b1; single_write = 1'b1;   // R11: ignored
        check_beats("R11", 49, 4, 0, 1, 3, 1);
        check_idle("R11");
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_sequential();
        t_interleaved();
        t_short_codes();
        t_full_page();
        t_precharge();
        t_restart();
        t_single_write();
        t_mode_latch();
        summary();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule